// File: doc/BRIEF.md
# Multi-Channel Shadowed PWM Generator

This block produces one pulse-width-modulated output per channel. Each channel has its own period, high-time and phase-start value, all counted in input clock cycles. Software programs the block through a simple memory-mapped register port: an address, a write strobe, write data and combinational read data.

Changes to a channel's timing are staged. A write only updates a shadow copy, and every staged value moves into the running counters together when software issues a global load command. By default the load waits until every enabled channel has finished its current cycle. In align mode it takes effect on the command itself, and all channels restart from count zero together. A global hold bit keeps the whole core idle with its outputs low. The hold bit is set out of reset and software clears it to start the core.

Top module: `shadow_pwm_gen`

## Requirements
- R1: After reset the control word (0x10) reads 0x1 with the hold bit (bit 0) set and the mode word (0x18) reads 0. Address 0x0C reads the identification constant 0x601A3471, 0x14 reads the channel count, 0x04 reads the version word (default 0x00010100), and 0x08 is a 32-bit scratch word that reads back what was written.
- R2: Channel registers sit at 0x40+4n (period), 0x80+4n (high time) and 0xC0+4n (phase start) and read back the staged value. Writing them leaves the outputs unchanged until a load is applied.
- R3: Writing 1 to bit 1 of the control word issues a load command. That bit always reads back as 0.
- R4: With align mode on (bit 1 of 0x18), a load is applied at the clock edge that accepts the command. All channel counters are 0 in the following cycle.
- R5: With align mode off and the core running, a pending load is applied at the first edge at which every channel with a nonzero period is in the last count of its cycle. Until then the old settings keep driving the outputs.
- R6: A channel's counter runs 0 to period-1 and wraps. The output is high while phase <= count < phase + high time.
- R7: A period of 0 holds the output low. A high time of 0 holds it low. A high time at or above the period keeps it high from the phase start to the end of the cycle.
- R8: While the hold bit is set, all counters stay at 0 and all outputs are low, while staged and running settings are kept. A load issued during hold is applied at once. After hold is cleared, counting resumes from 0.
- R9: Unmapped addresses, addresses not on a 4-byte boundary, and channel indices at or above the channel count read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The waveform is first checked with hand-picked settings covering a disabled channel, a zero high time, a high time longer than the period and a nonzero phase. These tell the comparison boundaries apart from the counter wrap. Random period, high-time and phase sets are then loaded in align mode, and each set is compared cycle by cycle against a reference waveform computed in the bench. In non-aligned mode, small random periods make the common end-of-cycle point come at different distances from the command, which separates applying on the command from applying at the shared cycle end. A hold phase shows that outputs go low while staged and running settings survive.

// File: rtl/pwm_pkg.sv
// Package: shared register map constants and decode types for the
// shadowed PWM generator. Assumes 32-bit word-aligned register slots.
package pwm_pkg;

    // Global register byte offsets (low byte of the address)
    localparam logic [7:0] OFS_VERSION = 8'h04;
    localparam logic [7:0] OFS_SCRATCH = 8'h08;
    localparam logic [7:0] OFS_IDENT   = 8'h0C;
    localparam logic [7:0] OFS_CTRL    = 8'h10;
    localparam logic [7:0] OFS_CHCOUNT = 8'h14;
    localparam logic [7:0] OFS_MODE    = 8'h18;

    // Bit positions inside the control and mode words
    localparam int CTRL_HOLD_BIT  = 0;
    localparam int CTRL_LOAD_BIT  = 1;
    localparam int MODE_ALIGN_BIT = 1;

    // Width of the channel index field (address bits 5:2)
    localparam int IDX_W = 4;

    // Address bits 7:6 select the register bank
    typedef enum logic [1:0] {
        BANK_GLOBAL = 2'b00,
        BANK_PERIOD = 2'b01,
        BANK_HIGH   = 2'b10,
        BANK_PHASE  = 2'b11
    } bank_e;

endpackage

// File: rtl/pwm_regs.sv
// Module: pwm_regs
// Register decode, global control bits and the staged (shadow) channel
// settings. Reads are combinational. Assumes ADDR_W >= 8 and NUM_CH <= 16.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          CNT_W   = 16,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] IDENT   = 32'h601A_3471,
    parameter logic [31:0] VERSION = 32'h0001_0100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          hold,
    output logic                          align,
    output logic                          load_cmd,
    output logic [NUM_CH-1:0][CNT_W-1:0]  sh_period,
    output logic [NUM_CH-1:0][CNT_W-1:0]  sh_high,
    output logic [NUM_CH-1:0][CNT_W-1:0]  sh_phase
);

    logic              hi_ok;
    logic              aligned;
    bank_e             bank;
    logic [IDX_W-1:0]  ch_idx;
    logic              ch_ok;
    logic              glob_hit;
    logic [7:0]        low_ofs;
    logic [DATA_W-1:0] scratch;
    logic [CNT_W-1:0]  rd_ch_val;

    // Address field split and legality
    always_comb begin
        hi_ok    = ((bus_addr >> 8) == '0);
        aligned  = (bus_addr[1:0] == 2'b00);
        bank     = bank_e'(bus_addr[7:6]);
        ch_idx   = bus_addr[5:2];
        low_ofs  = bus_addr[7:0];
        ch_ok    = hi_ok && aligned && (bank != BANK_GLOBAL) && (32'(ch_idx) < NUM_CH);
        glob_hit = hi_ok && aligned && (bank == BANK_GLOBAL);
    end

    // Load command is a one-cycle pulse from a control write; nothing stores it
    assign load_cmd = bus_wr && glob_hit && (low_ofs == OFS_CTRL) && bus_wdata[CTRL_LOAD_BIT];

    // Global writable words: hold bit, align mode, scratch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold    <= 1'b1;
            align   <= 1'b0;
            scratch <= '0;
        end else if (bus_wr && glob_hit) begin
            if (low_ofs == OFS_CTRL)    hold    <= bus_wdata[CTRL_HOLD_BIT];
            if (low_ofs == OFS_MODE)    align   <= bus_wdata[MODE_ALIGN_BIT];
            if (low_ofs == OFS_SCRATCH) scratch <= bus_wdata;
        end
    end

    // Per-channel staged settings, one register set per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_shadow
        logic sel;
        assign sel = bus_wr && ch_ok && (ch_idx == IDX_W'(c));

        // Capture a staged value for this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_period[c] <= '0;
                sh_high[c]   <= '0;
                sh_phase[c]  <= '0;
            end else if (sel) begin
                case (bank)
                    BANK_PERIOD: sh_period[c] <= bus_wdata[CNT_W-1:0];
                    BANK_HIGH:   sh_high[c]   <= bus_wdata[CNT_W-1:0];
                    BANK_PHASE:  sh_phase[c]  <= bus_wdata[CNT_W-1:0];
                    default:     ;
                endcase
            end
        end
    end

    // Pick the staged value of the addressed channel
    always_comb begin
        rd_ch_val = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == IDX_W'(c)) begin
                case (bank)
                    BANK_PERIOD: rd_ch_val = sh_period[c];
                    BANK_HIGH:   rd_ch_val = sh_high[c];
                    BANK_PHASE:  rd_ch_val = sh_phase[c];
                    default:     rd_ch_val = '0;
                endcase
            end
        end
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (ch_ok) begin
            bus_rdata = DATA_W'(rd_ch_val);
        end else if (glob_hit) begin
            case (low_ofs)
                OFS_VERSION: bus_rdata = DATA_W'(VERSION);
                OFS_SCRATCH: bus_rdata = scratch;
                OFS_IDENT:   bus_rdata = DATA_W'(IDENT);
                OFS_CTRL:    bus_rdata = DATA_W'(hold);
                OFS_CHCOUNT: bus_rdata = DATA_W'(NUM_CH);
                OFS_MODE:    bus_rdata = DATA_W'({align, 1'b0});
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R3
    load_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_hit && low_ofs == OFS_CTRL) |-> (bus_rdata[CTRL_LOAD_BIT] == 1'b0));

endmodule

// File: rtl/pwm_load_ctrl.sv
// Module: pwm_load_ctrl
// Sequences the global load. It applies at once in align mode or while the
// core is held. Otherwise it waits for the common end of cycle across channels.
// Assumes load_cmd is a single-cycle pulse.
module pwm_load_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic load_cmd,
    input  logic align,
    input  logic hold,
    input  logic all_end,
    output logic apply,
    output logic pending
);

    logic want;

    // Decide whether the staged settings move this cycle
    always_comb begin
        want  = load_cmd || pending;
        apply = want && (align || hold || all_end);
    end

    // Remember a load that is still waiting for the shared cycle end
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= want && !apply;
    end

    // R4
    align_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cmd && align) |=> !pending);

endmodule

// File: rtl/pwm_channel.sv
// Module: pwm_channel
// One PWM channel: running settings, the cycle counter and the high-window
// compare. Assumes apply is asserted for a single cycle per load.
module pwm_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             apply,
    input  logic [CNT_W-1:0] sh_period,
    input  logic [CNT_W-1:0] sh_high,
    input  logic [CNT_W-1:0] sh_phase,
    output logic             pwm,
    output logic             at_end
);

    logic [CNT_W-1:0] act_period;
    logic [CNT_W-1:0] act_high;
    logic [CNT_W-1:0] act_phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   stop;
    logic             last;

    // Running settings are copied from the staged ones only on apply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
            act_high   <= '0;
            act_phase  <= '0;
        end else if (apply) begin
            act_period <= sh_period;
            act_high   <= sh_high;
            act_phase  <= sh_phase;
        end
    end

    // Last count of the cycle (a disabled channel always counts as ended)
    assign last   = (act_period == '0) || (cnt == act_period - 1'b1);
    assign at_end = last;

    // Cycle counter: cleared by hold or apply, wraps after period-1
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (hold || apply) cnt <= '0;
        else if (last)          cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // High window compare: phase <= cnt < phase + high
    always_comb begin
        stop = {1'b0, act_phase} + {1'b0, act_high};
        pwm  = !hold && (act_period != '0) && (cnt >= act_phase) && ({1'b0, cnt} < stop);
    end

    // R6
    cnt_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_period != '0) |-> (cnt < act_period));

    // R8
    hold_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0));

    // R2
    staged_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable({act_period, act_high, act_phase}));

    // R4
    apply_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (cnt == '0));

endmodule

// File: rtl/shadow_pwm_gen.sv
// Module: shadow_pwm_gen
// Top level: register port, load sequencer and one generated channel per
// output. Assumes a single clock domain and word-aligned register accesses.
module shadow_pwm_gen #(
    parameter int          NUM_CH  = 4,
    parameter int          CNT_W   = 16,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] IDENT   = 32'h601A_3471,
    parameter logic [31:0] VERSION = 32'h0001_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic                         hold;
    logic                         align;
    logic                         load_cmd;
    logic                         apply;
    logic                         pending;
    logic [NUM_CH-1:0]            ch_end;
    logic [NUM_CH-1:0][CNT_W-1:0] sh_period;
    logic [NUM_CH-1:0][CNT_W-1:0] sh_high;
    logic [NUM_CH-1:0][CNT_W-1:0] sh_phase;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .IDENT  (IDENT),
        .VERSION(VERSION)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .hold     (hold),
        .align    (align),
        .load_cmd (load_cmd),
        .sh_period(sh_period),
        .sh_high  (sh_high),
        .sh_phase (sh_phase)
    );

    pwm_load_ctrl u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_cmd(load_cmd),
        .align   (align),
        .hold    (hold),
        .all_end (&ch_end),
        .apply   (apply),
        .pending (pending)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (hold),
            .apply    (apply),
            .sh_period(sh_period[c]),
            .sh_high  (sh_high[c]),
            .sh_phase (sh_phase[c]),
            .pwm      (pwm_out[c]),
            .at_end   (ch_end[c])
        );
    end

    // R8
    hold_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) && hold |-> (pwm_out == '0));

    // R5
    wait_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !align && !hold && !(&ch_end)) |=> pending);

endmodule

// File: tb/tb_shadow_pwm_gen.sv
// Bench: directed corner cases plus seeded random settings, with the
// expected waveform computed from the requirements.
module tb_shadow_pwm_gen;

    localparam int NCH = 4;
    localparam logic [7:0] A_VER = 8'h04, A_SCR = 8'h08, A_ID = 8'h0C,
                           A_CTL = 8'h10, A_CNT = 8'h14, A_MODE = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    int edges = 0;

    int s_per[NCH], s_hi[NCH], s_ph[NCH];
    int m_per[NCH], m_hi[NCH], m_ph[NCH];
    int ref_edge = 0;
    bit m_hold = 1'b1;

    shadow_pwm_gen dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata == 32'(exp), req, int'(bus_rdata), exp);
    endtask

    function automatic bit exp_out(input int c, input int n);
        int k;
        if (m_hold || m_per[c] == 0) return 1'b0;
        k = (n - ref_edge) % m_per[c];
        return (k >= m_ph[c]) && (k < m_ph[c] + m_hi[c]);
    endfunction

    task automatic cmp_now(input string req);
        logic [NCH-1:0] e;
        for (int c = 0; c < NCH; c++) e[c] = exp_out(c, edges);
        check(pwm_out == e, req, int'(pwm_out), int'(e));
    endtask

    task automatic run_cmp(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cmp_now(req);
        end
    endtask

    task automatic stage(input int c, input int p, input int h, input int f);
        s_per[c] = p; s_hi[c] = h; s_ph[c] = f;
        wr(8'h40 + 8'(4*c), 32'(p));
        wr(8'h80 + 8'(4*c), 32'(h));
        wr(8'hC0 + 8'(4*c), 32'(f));
    endtask

    task automatic take_shadow();
        for (int c = 0; c < NCH; c++) begin
            m_per[c] = s_per[c]; m_hi[c] = s_hi[c]; m_ph[c] = s_ph[c];
        end
    endtask

    // Load with align mode off: follow the old waveform until the common end
    task automatic load_waiting();
        int x;
        bit ok;
        wr(A_CTL, 32'h2);
        x = edges;
        for (int g = 0; g < 2000; g++) begin
            ok = 1'b1;
            for (int c = 0; c < NCH; c++)
                if (m_per[c] != 0 && ((x - 1 - ref_edge) % m_per[c]) != m_per[c] - 1) ok = 1'b0;
            if (ok) break;
            x++;
        end
        while (edges < x) begin
            cmp_now("R5 old settings until cycle end");
            @(negedge clk);
        end
        take_shadow();
        ref_edge = x;
        cmp_now("R5 applied at common end");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < NCH; c++) begin
            s_per[c] = 0; s_hi[c] = 0; s_ph[c] = 0;
            m_per[c] = 0; m_hi[c] = 0; m_ph[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == '0, "R1 outputs low after reset", int'(pwm_out), 0);

        // R1 identity and reset values
        rd_chk(A_CTL, 1, "R1 control word reset");
        rd_chk(A_MODE, 0, "R1 mode word reset");
        rd_chk(A_ID, 32'h601A3471, "R1 ident");
        rd_chk(A_CNT, NCH, "R1 channel count");
        rd_chk(A_VER, 32'h00010100, "R1 version");
        wr(A_SCR, 32'hA5C3_0F96);
        rd_chk(A_SCR, 32'hA5C3_0F96, "R1 scratch");

        // R9 unmapped, unaligned and out-of-range reads/writes
        wr(8'h40 + 8'(4*NCH), 32'h55);
        rd_chk(8'h40 + 8'(4*NCH), 0, "R9 channel beyond count");
        rd_chk(8'h1C, 0, "R9 unmapped");
        wr(8'h41, 32'h77);
        rd_chk(8'h41, 0, "R9 unaligned read");
        rd_chk(8'h40, 0, "R9 unaligned write ignored");

        // Directed corner settings, loaded during hold (R8 immediate load)
        stage(0, 10, 3, 2);
        stage(1, 0, 5, 0);
        stage(2, 6, 0, 1);
        stage(3, 5, 9, 1);
        rd_chk(8'hC0, 2, "R2 staged readback");
        run_cmp(3, "R8 held outputs low");
        wr(A_CTL, 32'h3);
        take_shadow();
        run_cmp(4, "R8 held after load");
        rd_chk(A_CTL, 1, "R3 load bit reads 0");
        wr(A_CTL, 32'h0);
        m_hold = 1'b0;
        ref_edge = edges;
        cmp_now("R6 first count");
        run_cmp(30, "R6 R7 directed waveform");

        // Align mode with random settings (R4)
        wr(A_MODE, 32'h2);
        rd_chk(A_MODE, 2, "R4 mode readback");
        for (int r = 0; r < 6; r++) begin
            for (int c = 0; c < NCH; c++)
                stage(c, $urandom % 16, $urandom % 20, $urandom % 16);
            run_cmp(8, "R2 outputs unchanged before load");
            wr(A_CTL, 32'h2);
            take_shadow();
            ref_edge = edges;
            cmp_now("R4 restart at count 0");
            run_cmp(40, "R4 R6 random waveform");
        end

        // Small periods so the common end stays near
        for (int c = 0; c < NCH; c++) stage(c, 1 + c, 1, 0);
        wr(A_CTL, 32'h2);
        take_shadow();
        ref_edge = edges;
        run_cmp(10, "R4 small periods");

        // Align mode off (R5)
        wr(A_MODE, 32'h0);
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < NCH; c++)
                stage(c, 1 + ($urandom % 6), $urandom % 7, $urandom % 5);
            load_waiting();
            run_cmp(30, "R5 R6 waveform after waiting load");
        end

        // Hold keeps settings (R8)
        wr(A_CTL, 32'h1);
        m_hold = 1'b1;
        run_cmp(6, "R8 outputs low in hold");
        rd_chk(8'h40, s_per[0], "R8 staged kept in hold");
        wr(A_CTL, 32'h0);
        m_hold = 1'b0;
        ref_edge = edges;
        cmp_now("R8 resume from 0");
        run_cmp(25, "R8 running settings kept");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule